// File: doc/BRIEF.md
# Fetch Next-Line and Way Predictor

This block sits beside an instruction cache and tells the fetch unit where to go next. Every aligned 16-byte fetch chunk (four 32-bit instructions) maps to one predictor entry. That entry holds the cache set index of the next line to fetch and the way within that set. The fetch unit presents the address of the chunk it is fetching now. One cycle later it receives the predicted next line and way, so it can start the following cache access without waiting for branch resolution. In effect the table acts as a branch target buffer that works at line granularity.

When a branch in a chunk resolves, the back end sends an update. A taken branch stores its target line and way, and the entry is marked as a target prediction. A not-taken resolution sets the entry back to the chunk's fall-through line together with the way that line was found in. An entry that has never been trained, whether after reset or because it was never written, predicts the sequential next line in way 0. Branches that change direction and indirect jumps with changing targets will mispredict, and the next update corrects the entry. There are no tags, so chunks that share index bits also share an entry.

Lookups use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The prediction appears on the next cycle with `pred_valid` high, and it stays on the outputs, unchanged, until it is taken on an edge where `pred_ready` is high. While a prediction is waiting, `req_ready` is low. A request can be accepted on the same edge that drains the waiting prediction. Updates are a plain strobe and are never back-pressured.

Top module: `fetch_line_way_pred`

## Requirements
- R1: After reset `pred_valid` is 0, `req_ready` is 1, and every entry is untrained. Training done before a reset has no effect on predictions made after it.
- R2: An untrained entry predicts line = bits [11:6] of (chunk address + 16), which is the line holding the next sequential chunk, with `pred_way` = 0 and `pred_target` = 0.
- R3: An update with `upd_taken`=1 makes later lookups of that entry return `upd_line` and `upd_way` with `pred_target`=1.
- R4: An update with `upd_taken`=0 makes the entry return the fall-through line (bits [11:6] of `upd_pc`+16) and `upd_way`, with `pred_target`=0. The value on `upd_line` is ignored.
- R5: A later update to an entry fully replaces whatever an earlier update wrote there.
- R6: When an update and an accepted lookup hit the same entry on the same edge, the prediction shows the newly written values.
- R7: A request accepted on edge k gives `pred_valid`=1 right after edge k.
- R8: While `pred_valid`=1 and `pred_ready`=0, `req_ready` is 0 and `pred_line`, `pred_way` and `pred_target` hold steady. This is true even if updates arrive during the stall.
- R9: The entry index is address bits [9:4]. An update to one index leaves the other indices unchanged.
- R10: Two addresses that match in bits [9:4] share one entry (no tag check).
- R11: The sequential line wraps modulo 64, so the last chunk of line 63 predicts line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_pc | input | 32 | Byte address of the current fetch chunk |
| pred_valid | output | 1 | Prediction present |
| pred_ready | input | 1 | Consumer takes the prediction |
| pred_line | output | 6 | Predicted next cache set index |
| pred_way | output | 2 | Predicted way in that set |
| pred_target | output | 1 | 1 when the entry holds a taken-branch target |
| upd_valid | input | 1 | Training strobe |
| upd_pc | input | 32 | Address of the chunk being trained |
| upd_taken | input | 1 | Branch in the chunk resolved as taken |
| upd_line | input | 6 | Actual target line (used only when taken) |
| upd_way | input | 2 | Way of the actual next line |

## Verification
The bench covers these corner cases:
- The last chunk of a line and the last line of the cache. A design that uses the wrong bits for the sequential line would predict the current line, or line 64 truncated wrongly, instead of the next line or line 0.
- A not-taken update that carries a junk `upd_line`. This catches a design that stores the wrong field.
- Aliased addresses, which expose any hidden tag check.
- An update and a lookup to the same entry on the same edge. A design without write-to-read forwarding would return the stale entry here.
- A stalled output while an update to the same entry arrives. A design with a leaking hold register would change the prediction before it is consumed.
- A second reset after training, which catches valid bits that do not clear.

// File: rtl/lwp_pkg.sv
package lwp_pkg;
  // Where a prediction came from; the stored kind bit and the cold path map onto it.
  typedef enum logic [1:0] {
    SRC_COLD   = 2'd0,
    SRC_FALL   = 2'd1,
    SRC_TARGET = 2'd2
  } pred_src_e;

  function automatic logic is_target(input pred_src_e s);
    return s == SRC_TARGET;
  endfunction
endpackage

// File: rtl/lwp_seq_line.sv
// Line index of the chunk that follows the given chunk in address order.
module lwp_seq_line #(
  parameter int PC_W      = 32,
  parameter int CHUNK_OFF = 4,
  parameter int LINE_OFF  = 6,
  parameter int LINE_W    = 6
) (
  input  logic [PC_W-1:0]   pc,
  output logic [LINE_W-1:0] line
);
  localparam int TOP   = LINE_OFF + LINE_W;
  localparam int SPAN  = TOP - CHUNK_OFF;

  logic [SPAN-1:0] chunk_no;
  logic [SPAN-1:0] chunk_nx;

  always_comb begin
    chunk_no = pc[TOP-1:CHUNK_OFF];
    chunk_nx = chunk_no + SPAN'(1);
    line     = chunk_nx[SPAN-1 -: LINE_W];
  end
endmodule

// File: rtl/lwp_table.sv
// Flat predictor storage with write-to-read forwarding.
module lwp_table
  import lwp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int LINE_W  = 6,
  parameter int WAY_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_tgt,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output pred_src_e         rd_src,
  output logic [LINE_W-1:0] rd_line,
  output logic [WAY_W-1:0]  rd_way
);
  typedef struct packed {
    logic              vld;
    logic              tgt;
    logic [LINE_W-1:0] line;
    logic [WAY_W-1:0]  way;
  } ent_t;

  ent_t ent [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent[i] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        ent[i] <= '{vld: 1'b1, tgt: wr_tgt, line: wr_line, way: wr_way};
      end
    end
  end

  ent_t rd_e;
  always_comb begin
    if (wr_en && wr_idx == rd_idx)
      rd_e = '{vld: 1'b1, tgt: wr_tgt, line: wr_line, way: wr_way};
    else
      rd_e = ent[rd_idx];
    rd_hit  = rd_e.vld;
    rd_line = rd_e.line;
    rd_way  = rd_e.way;
    if (!rd_e.vld)    rd_src = SRC_COLD;
    else if (rd_e.tgt) rd_src = SRC_TARGET;
    else              rd_src = SRC_FALL;
  end
endmodule

// File: rtl/lwp_out_stage.sv
// One-deep valid/ready register holding a prediction until consumed.
module lwp_out_stage #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R8: a waiting prediction neither vanishes nor changes
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid) && !$past(out_ready)) |-> (out_valid && $stable(out_data)));

  // R7: an accepted request shows up on the next cycle
  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) |-> out_valid);
endmodule

// File: rtl/fetch_line_way_pred.sv
module fetch_line_way_pred
  import lwp_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int CHUNK_BYTES = 16,
  parameter int LINE_BYTES  = 64,
  parameter int SETS        = 64,
  parameter int WAYS        = 4,
  parameter int ENTRIES     = 64,
  localparam int LINE_W     = $clog2(SETS),
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PC_W-1:0]   req_pc,
  output logic              pred_valid,
  input  logic              pred_ready,
  output logic [LINE_W-1:0] pred_line,
  output logic [WAY_W-1:0]  pred_way,
  output logic              pred_target,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [LINE_W-1:0] upd_line,
  input  logic [WAY_W-1:0]  upd_way
);
  localparam int CHUNK_OFF = $clog2(CHUNK_BYTES);
  localparam int LINE_OFF  = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int PAY_W     = LINE_W + WAY_W + 1;

  logic [IDX_W-1:0]  req_idx, upd_idx;
  logic [LINE_W-1:0] req_seq, upd_fall;
  logic              rd_hit;
  pred_src_e         rd_src;
  logic [LINE_W-1:0] rd_line, wr_line;
  logic [WAY_W-1:0]  rd_way;
  logic [PAY_W-1:0]  pay_in, pay_out;

  assign req_idx = req_pc[CHUNK_OFF +: IDX_W];
  assign upd_idx = upd_pc[CHUNK_OFF +: IDX_W];

  lwp_seq_line #(.PC_W(PC_W), .CHUNK_OFF(CHUNK_OFF), .LINE_OFF(LINE_OFF), .LINE_W(LINE_W))
    u_seq_req (.pc(req_pc), .line(req_seq));

  lwp_seq_line #(.PC_W(PC_W), .CHUNK_OFF(CHUNK_OFF), .LINE_OFF(LINE_OFF), .LINE_W(LINE_W))
    u_seq_upd (.pc(upd_pc), .line(upd_fall));

  assign wr_line = upd_taken ? upd_line : upd_fall;

  lwp_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .WAY_W(WAY_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_tgt(upd_taken),
    .wr_line(wr_line), .wr_way(upd_way),
    .rd_idx(req_idx), .rd_hit(rd_hit), .rd_src(rd_src),
    .rd_line(rd_line), .rd_way(rd_way)
  );

  always_comb begin
    if (rd_hit) pay_in = {is_target(rd_src), rd_line, rd_way};
    else        pay_in = {1'b0, req_seq, {WAY_W{1'b0}}};
  end

  lwp_out_stage #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(pred_valid), .out_ready(pred_ready), .out_data(pay_out)
  );

  assign {pred_target, pred_line, pred_way} = pay_out;

  // R1: the first cycle after reset carries no prediction
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !pred_valid);

  // R6: same-edge taken update to the looked-up entry is forwarded
  a_r6_write_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && upd_valid && upd_taken && upd_idx == req_idx && rst_n)
      |-> (pred_target && pred_line == $past(upd_line) && pred_way == $past(upd_way)));

  // R4: same-edge not-taken update yields a fall-through entry with the given way
  a_r4_fall_way: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && upd_valid && !upd_taken && upd_idx == req_idx && rst_n)
      |-> (!pred_target && pred_way == $past(upd_way)));

  // R8: no new request is accepted while a prediction waits
  a_r8_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_ready) |-> !req_ready);
endmodule

// File: tb/sim_fetch_line_way_pred.sv
module sim_fetch_line_way_pred;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, pred_valid, pred_ready = 1'b1, pred_target;
  logic [31:0] req_pc = '0, upd_pc = '0;
  logic [5:0]  pred_line, upd_line = '0;
  logic [1:0]  pred_way, upd_way = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;

  fetch_line_way_pred u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_line(pred_line),
    .pred_way(pred_way), .pred_target(pred_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_line(upd_line), .upd_way(upd_way)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_pred(input string rq, input logic [5:0] l, input logic [1:0] w, input logic t);
    chk(rq, "pred_valid", 32'(pred_valid), 32'd1);
    chk(rq, "pred_line", 32'(pred_line), 32'(l));
    chk(rq, "pred_way", 32'(pred_way), 32'(w));
    chk(rq, "pred_target", 32'(pred_target), 32'(t));
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic        up_en;
    logic        up_tk;
    logic [31:0] up_pc;
    logic [5:0]  up_line;
    logic [1:0]  up_way;
    logic [31:0] lk_pc;
    logic [5:0]  ex_line;
    logic [1:0]  ex_way;
    logic        ex_tgt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b0, 1'b0, 32'h0,   6'd0,  2'd0, 32'h100, 6'd4,  2'd0, 1'b0}, // R2 cold, first chunk
    '{4'd2,  1'b0, 1'b0, 32'h0,   6'd0,  2'd0, 32'h1F0, 6'd8,  2'd0, 1'b0}, // R2 cold, last chunk of line
    '{4'd11, 1'b0, 1'b0, 32'h0,   6'd0,  2'd0, 32'hFF0, 6'd0,  2'd0, 1'b0}, // R11 wrap
    '{4'd3,  1'b1, 1'b1, 32'h104, 6'd37, 2'd2, 32'h108, 6'd37, 2'd2, 1'b1}, // R3 taken
    '{4'd10, 1'b0, 1'b0, 32'h0,   6'd0,  2'd0, 32'h504, 6'd37, 2'd2, 1'b1}, // R10 alias
    '{4'd9,  1'b0, 1'b0, 32'h0,   6'd0,  2'd0, 32'h114, 6'd4,  2'd0, 1'b0}, // R9 neighbour cold
    '{4'd5,  1'b1, 1'b1, 32'h100, 6'd12, 2'd3, 32'h100, 6'd12, 2'd3, 1'b1}, // R5 retrain
    '{4'd4,  1'b1, 1'b0, 32'h100, 6'd50, 2'd1, 32'h100, 6'd4,  2'd1, 1'b0}, // R4 not taken
    '{4'd4,  1'b1, 1'b0, 32'h7F0, 6'd9,  2'd2, 32'h3F0, 6'd32, 2'd2, 1'b0}, // R4 fall-through across line
    '{4'd3,  1'b1, 1'b1, 32'h050, 6'd1,  2'd1, 32'h05C, 6'd1,  2'd1, 1'b1}  // R3 second index
  };

  task automatic lookup(input logic [31:0] pc);
    @(negedge clk);
    req_pc = pc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1", "pred_valid after reset", 32'(pred_valid), 32'd0);
    chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].rq);
      if (VECS[i].up_en) begin
        @(negedge clk);
        upd_valid = 1'b1; upd_taken = VECS[i].up_tk; upd_pc = VECS[i].up_pc;
        upd_line = VECS[i].up_line; upd_way = VECS[i].up_way;
        @(negedge clk);
        upd_valid = 1'b0;
      end
      lookup(VECS[i].lk_pc);
      chk_pred(rq, VECS[i].ex_line, VECS[i].ex_way, VECS[i].ex_tgt);
    end

    // R7: no prediction before the accepting edge, one right after
    @(negedge clk);
    req_pc = 32'h114; req_valid = 1'b1;
    chk("R7", "pred_valid before accept", 32'(pred_valid), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "pred_valid after accept", 32'(pred_valid), 32'd1);

    // R6: update and lookup of entry 32 on the same edge
    @(negedge clk);
    upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = 32'h200; upd_line = 6'd21; upd_way = 2'd3;
    req_valid = 1'b1; req_pc = 32'h204;
    @(negedge clk);
    upd_valid = 1'b0; req_valid = 1'b0;
    chk_pred("R6", 6'd21, 2'd3, 1'b1);

    // R8: stall, with an update to the held entry arriving meanwhile
    @(negedge clk);
    pred_ready = 1'b0;
    lookup(32'h108);
    chk_pred("R8", 6'd4, 2'd1, 1'b0);
    req_valid = 1'b1; req_pc = 32'h100;
    upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = 32'h100; upd_line = 6'd40; upd_way = 2'd2;
    @(negedge clk);
    upd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R8", "req_ready stalled", 32'(req_ready), 32'd0);
      chk_pred("R8", 6'd4, 2'd1, 1'b0);
      @(negedge clk);
    end
    pred_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk_pred("R8", 6'd40, 2'd2, 1'b1);

    // R1: a second reset forgets training
    do_reset();
    lookup(32'h108);
    chk_pred("R1", 6'd4, 2'd0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 5000);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule